// File: doc/BRIEF.md
# Instruction Fetch and Decode Sequencer

This block is the hardwired sequencing core of a small 16-bit accumulator machine. A 4-bit step counter runs through sixteen steps. Each step is decoded into one of sixteen one-hot timing lines. A fixed schedule of register transfers is tied to those lines. Step 0 copies the program counter into the address register. Step 1 reads the instruction word and advances the program counter. Step 2 splits the instruction into its indirect flag, its 3-bit opcode and its 12-bit address. Step 3 either follows one level of indirection or finishes a register-reference instruction.

The block owns the program counter, the address register, the instruction register, the indirect flag and a latched opcode. The opcode is decoded into eight one-hot lines. Only the address register drives the memory address. The memory read is combinational and completes within one clock cycle. A 3-bit code names which source currently drives the shared bus.

Memory-reference instructions hand over to an external execute stage at step 4. The block raises a one-cycle strobe at that point. It then waits for a done pulse, which sends the counter back to step 0. Selected opcodes are instead marked as single-step operations, and these clear the counter at step 4 on their own. A halt request freezes the sequencer until reset.

Top module: `instr_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the step counter goes to 0 and PC, AR, IR, the indirect flag and the latched opcode go to 0. After that edge, `t_sig` = 16'h0001 and `d_sig` = 8'h01, `exec_stb` is low, and `mem_we` is always 0.
- R2: `t_sig` is one-hot, with bit n set when the step counter equals n. Unless a clear condition applies, the counter advances by one at each edge and wraps from step 15 to step 0.
- R3: In step 0, `bus_sel` = 3'b010 (PC source). At the closing edge AR takes the PC value. `mem_addr` always equals AR.
- R4: In step 1, `bus_sel` = 3'b111 (memory source). At the closing edge IR takes `mem_rdata` and PC increments by one, wrapping modulo 4096.
- R5: In step 2, `bus_sel` = 3'b101 (IR source). At the closing edge AR takes IR[11:0], the indirect flag takes IR[15] and the opcode takes IR[14:12]. From then on `d_sig` is the one-hot decode of that opcode, with bit k set for opcode k.
- R6: In step 3 with opcode 0..6 and the indirect flag set, `bus_sel` = 3'b111 and AR takes `mem_rdata`[11:0] at the closing edge. With the flag clear, `bus_sel` = 3'b000 and AR is unchanged.
- R7: In step 3 with opcode 7 (register-reference or I/O), the counter is cleared, so the next cycle is step 0.
- R8: In step 4 with opcode 3 (the default single-step mask 8'b0000_1000), the counter is cleared, so the next cycle is step 0.
- R9: `exec_stb` is high exactly in the step-4 cycle of an instruction with opcode 0..6.
- R10: `exec_done` clears the counter at an edge only when the step is 4 or higher and the opcode is 0..6. In steps 0..3 it has no effect on the sequence.
- R11: A high `halt_req` at an edge freezes the counter and every register at that edge and at every later edge until reset. While frozen, `exec_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Word read from memory at `mem_addr` |
| exec_done | input | 1 | Execute stage finished; returns to step 0 |
| halt_req | input | 1 | Freeze the sequencer until reset |
| mem_addr | output | 12 | Memory address (AR) |
| mem_we | output | 1 | Memory write enable, held low |
| bus_sel | output | 3 | Shared-bus source code |
| t_sig | output | 16 | One-hot timing lines |
| d_sig | output | 8 | One-hot opcode lines |
| exec_stb | output | 1 | Start pulse for the execute stage |
| pc_q | output | 12 | Program counter |
| ar_q | output | 12 | Address register |
| ir_q | output | 16 | Instruction register |
| i_flag | output | 1 | Indirect flag |

## Verification
The bench sweeps every combination of opcode and indirect flag several times. Each instruction's done pulse arrives at a delay that depends on its opcode. One class of instruction never gets a done pulse, so the counter must wrap through step 15. If the step-3 indirection were wrong, AR would keep the instruction's own address field, or it would take all 16 memory bits instead of the low 12. If the clear products were wrong, an opcode-7 or opcode-3 instruction would run into extra steps, or every instruction would be cut short. Stray done pulses are driven during steps 0..3, and a design that honoured them would restart in the middle of a fetch. A halt is raised partway through execution, and a design that leaked a load during the freeze would move the PC or the timing lines.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_PC   = 3'b010,
    SRC_IR   = 3'b101,
    SRC_MEM  = 3'b111
  } bus_src_e;
endpackage

// File: rtl/instr_seq_onehot.sv
module instr_seq_onehot #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]        code,
  output logic [(1<<W)-1:0]   hot
);
  localparam int unsigned N = 1 << W;
  for (genvar k = 0; k < N; k++) begin : g_line
    assign hot[k] = (code == W'(k));
  end
endmodule

// File: rtl/instr_seq_counter.sv
module instr_seq_counter #(
  parameter int unsigned SCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           hold,
  output logic [SCW-1:0] sc
);
  function automatic logic [SCW-1:0] step_next(input logic [SCW-1:0] v);
    return v + SCW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       sc <= '0;
    else if (hold) sc <= sc;
    else if (clr)  sc <= '0;
    else           sc <= step_next(sc);
  end
endmodule

// File: rtl/instr_seq_regs.sv
module instr_seq_regs #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  parameter int unsigned OPW = 3,
  parameter logic [AW-1:0] PC_RESET = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           ld_ar_pc,
  input  logic           ld_ir,
  input  logic           ld_dec,
  input  logic           ld_ind,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  ar,
  output logic [DW-1:0]  ir,
  output logic           i_bit,
  output logic [OPW-1:0] op
);
  localparam int unsigned IBIT = DW - 1;
  localparam int unsigned OPHI = DW - 2;

  function automatic logic [AW-1:0] pc_inc(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= PC_RESET;
      ar    <= '0;
      ir    <= '0;
      i_bit <= 1'b0;
      op    <= '0;
    end else if (!hold) begin
      if (ld_ar_pc) ar <= pc;
      if (ld_ir) begin
        ir <= mem_rdata;
        pc <= pc_inc(pc);
      end
      if (ld_dec) begin
        ar    <= ir[AW-1:0];
        i_bit <= ir[IBIT];
        op    <= ir[OPHI -: OPW];
      end
      if (ld_ind) ar <= mem_rdata[AW-1:0];
    end
  end
endmodule

// File: rtl/instr_seq_ctrl.sv
module instr_seq_ctrl #(
  parameter int unsigned AW = 12,
  parameter int unsigned OPW = 3,
  parameter int unsigned SCW = 4,
  parameter int unsigned DW = 1 + OPW + AW,
  parameter logic [AW-1:0] PC_RESET = '0,
  parameter logic [(1<<OPW)-1:0] QUICK_MASK = 'b1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DW-1:0]         mem_rdata,
  input  logic                  exec_done,
  input  logic                  halt_req,
  output logic [AW-1:0]         mem_addr,
  output logic                  mem_we,
  output logic [2:0]            bus_sel,
  output logic [(1<<SCW)-1:0]   t_sig,
  output logic [(1<<OPW)-1:0]   d_sig,
  output logic                  exec_stb,
  output logic [AW-1:0]         pc_q,
  output logic [AW-1:0]         ar_q,
  output logic [DW-1:0]         ir_q,
  output logic                  i_flag
);
  import instr_seq_pkg::*;

  localparam int unsigned NT = 1 << SCW;
  localparam int unsigned ND = 1 << OPW;
  localparam logic [SCW-1:0] EXEC_FIRST = SCW'(4);

  logic [SCW-1:0] sc_q;
  logic [OPW-1:0] op_q;
  logic           halted_q;
  logic           freeze;
  logic           mem_ref;
  logic           ind_ld;
  logic           rr_clr;
  logic           quick_clr;
  logic           done_clr;
  logic           sc_clr;

  // halt latch: held until reset
  always_ff @(posedge clk) begin
    if (rst)           halted_q <= 1'b0;
    else if (halt_req) halted_q <= 1'b1;
  end

  assign freeze    = halted_q | halt_req;
  assign mem_ref   = ~d_sig[ND-1];
  assign ind_ld    = t_sig[3] & mem_ref & i_flag;
  assign rr_clr    = t_sig[3] & d_sig[ND-1];
  assign quick_clr = t_sig[4] & (|(d_sig & QUICK_MASK));
  assign done_clr  = exec_done & mem_ref & (sc_q >= EXEC_FIRST);
  assign sc_clr    = rr_clr | quick_clr | done_clr;

  instr_seq_counter #(.SCW(SCW)) u_counter (
    .clk  (clk),
    .rst  (rst),
    .clr  (sc_clr),
    .hold (freeze),
    .sc   (sc_q)
  );

  instr_seq_onehot #(.W(SCW)) u_tdec (
    .code (sc_q),
    .hot  (t_sig)
  );

  instr_seq_regs #(
    .AW(AW), .DW(DW), .OPW(OPW), .PC_RESET(PC_RESET)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hold      (freeze),
    .ld_ar_pc  (t_sig[0]),
    .ld_ir     (t_sig[1]),
    .ld_dec    (t_sig[2]),
    .ld_ind    (ind_ld),
    .mem_rdata (mem_rdata),
    .pc        (pc_q),
    .ar        (ar_q),
    .ir        (ir_q),
    .i_bit     (i_flag),
    .op        (op_q)
  );

  instr_seq_onehot #(.W(OPW)) u_ddec (
    .code (op_q),
    .hot  (d_sig)
  );

  always_comb begin
    bus_src_e src;
    src = SRC_NONE;
    if (t_sig[0])      src = SRC_PC;
    else if (t_sig[1]) src = SRC_MEM;
    else if (t_sig[2]) src = SRC_IR;
    else if (ind_ld)   src = SRC_MEM;
    bus_sel = src;
  end

  assign exec_stb = t_sig[4] & mem_ref & ~halted_q;
  assign mem_addr = ar_q;
  assign mem_we   = 1'b0;
endmodule

// File: rtl/instr_seq_ctrl_chk.sv
module instr_seq_ctrl_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned NT = 16,
  parameter int unsigned ND = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          halt_req,
  input logic          halted,
  input logic [NT-1:0] t_sig,
  input logic [ND-1:0] d_sig,
  input logic          exec_stb,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] ar_q
);
  // R2
  t_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(t_sig));

  // R5
  d_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(d_sig));

  // R3
  ar_from_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (t_sig[0] && !halted && !halt_req) |=> (ar_q == $past(pc_q)));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (t_sig[1] && !halted && !halt_req) |=> (pc_q == AW'($past(pc_q) + AW'(1))));

  // R7
  rr_return_chk: assert property (@(posedge clk) disable iff (rst)
    (t_sig[3] && d_sig[ND-1] && !halted && !halt_req) |=> t_sig[0]);

  // R9
  stb_window_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb |-> (t_sig[4] && !d_sig[ND-1]));

  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(t_sig) && $stable(pc_q) && $stable(ar_q) && !exec_stb));
endmodule

bind instr_seq_ctrl instr_seq_ctrl_chk #(
  .AW(AW), .NT(1 << SCW), .ND(1 << OPW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .halt_req (halt_req),
  .halted   (halted_q),
  .t_sig    (t_sig),
  .d_sig    (d_sig),
  .exec_stb (exec_stb),
  .pc_q     (pc_q),
  .ar_q     (ar_q)
);

// File: tb/instr_seq_ctrl_bench.sv
module instr_seq_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        exec_done = 1'b0;
  logic        halt_req = 1'b0;
  logic [15:0] mem [0:255];
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [2:0]  bus_sel;
  logic [15:0] t_sig;
  logic [7:0]  d_sig;
  logic        exec_stb;
  logic [11:0] pc_q, ar_q;
  logic [15:0] ir_q;
  logic        i_flag;
  wire  [15:0] mem_rdata = mem[mem_addr[7:0]];

  instr_seq_ctrl u_instr_seq_ctrl (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .exec_done(exec_done),
    .halt_req(halt_req), .mem_addr(mem_addr), .mem_we(mem_we),
    .bus_sel(bus_sel), .t_sig(t_sig), .d_sig(d_sig), .exec_stb(exec_stb),
    .pc_q(pc_q), .ar_q(ar_q), .ir_q(ir_q), .i_flag(i_flag)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  int          m_sc;
  logic [11:0] m_pc, m_ar;
  logic [15:0] m_ir;
  logic        m_i;
  logic [2:0]  m_op;
  logic        m_halt;
  string       t_tag, a_tag;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int done_delay(logic [2:0] op, logic ind);
    if (op == 3'd0 && ind) return 99;
    return int'(op);
  endfunction

  task automatic model_step();
    bit rr, qk, dn;
    int old_sc;
    if (rst) begin
      m_sc = 0; m_pc = '0; m_ar = '0; m_ir = '0; m_i = 0; m_op = '0; m_halt = 0;
      t_tag = "R1"; a_tag = "R1";
      return;
    end
    if (m_halt || halt_req) begin
      m_halt = 1;
      t_tag = "R11"; a_tag = "R11";
      return;
    end
    old_sc = m_sc;
    rr = (m_sc == 3) && (m_op == 3'd7);
    qk = (m_sc == 4) && (m_op == 3'd3);
    dn = exec_done && (m_sc >= 4) && (m_op != 3'd7);
    case (old_sc)
      0: m_ar = m_pc;
      1: begin m_ir = mem[m_ar[7:0]]; m_pc = m_pc + 12'd1; end
      2: begin m_ar = m_ir[11:0]; m_i = m_ir[15]; m_op = m_ir[14:12]; end
      3: if (m_op != 3'd7 && m_i) m_ar = mem[m_ar[7:0]][11:0];
      default: ;
    endcase
    m_sc = (rr || qk || dn) ? 0 : (m_sc + 1) % 16;
    t_tag = rr ? "R7" : qk ? "R8" : dn ? "R10" : "R2";
    case (old_sc)
      0: a_tag = "R3";
      1: a_tag = "R4";
      2: a_tag = "R5";
      default: a_tag = "R6";
    endcase
  endtask

  task automatic compare();
    logic [2:0] eb;
    string ptag, btag, dtag, stag;
    bit ov;
    ov = (t_tag == "R1") || (t_tag == "R11");
    ptag = ov ? t_tag : "R4";
    dtag = ov ? t_tag : "R5";
    stag = ov ? t_tag : "R9";
    case (m_sc)
      0: begin eb = 3'b010; btag = "R3"; end
      1: begin eb = 3'b111; btag = "R4"; end
      2: begin eb = 3'b101; btag = "R5"; end
      3: begin eb = (m_op != 3'd7 && m_i) ? 3'b111 : 3'b000; btag = "R6"; end
      default: begin eb = 3'b000; btag = "R6"; end
    endcase
    chk(t_tag, "t_sig", t_sig, 16'(1) << m_sc);
    chk(a_tag, "ar_q", {4'h0, ar_q}, {4'h0, m_ar});
    chk("R3", "mem_addr", {4'h0, mem_addr}, {4'h0, m_ar});
    chk(ptag, "pc_q", {4'h0, pc_q}, {4'h0, m_pc});
    chk(ptag, "ir_q", ir_q, m_ir);
    chk(dtag, "i_flag", {15'h0, i_flag}, {15'h0, m_i});
    chk(dtag, "d_sig", {8'h0, d_sig}, 16'(1) << m_op);
    chk(btag, "bus_sel", {13'h0, bus_sel}, {13'h0, eb});
    chk(stag, "exec_stb", {15'h0, exec_stb},
        {15'h0, (m_sc == 4 && m_op != 3'd7 && !m_halt)});
    chk("R1", "mem_we", {15'h0, mem_we}, 16'h0);
  endtask

  task automatic tick();
    exec_done = (m_sc == 4 + done_delay(m_op, m_i)) || (m_sc == 1 && (cyc % 3) == 0);
    model_step();
    @(posedge clk);
    #1;
    cyc++;
    compare();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cyc);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 256; k++) begin
      if (k < 64)       mem[k] = {k[0], k[3:1], 12'h080 + 12'(k)};
      else if (k < 128) mem[k] = 16'h0000 + 16'(k);
      else if (k < 192) mem[k] = 16'hF0C0 + 16'(k - 128);
      else              mem[k] = 16'h0000 + 16'(k);
    end
    m_sc = 0; m_op = '0; m_i = 0;
    #1;
    // R1 reset state
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    // sweep of all opcode / indirect combinations (R2..R10)
    repeat (400) tick();
    // reset in the middle of a fetch (R1)
    for (int w = 0; w < 40 && m_sc != 2; w++) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    repeat (60) tick();
    // halt while executing (R11)
    for (int w = 0; w < 60 && !(m_sc == 5 && m_op != 3'd7); w++) tick();
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    repeat (20) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    repeat (80) tick();
    finish_run();
  end
endmodule